// File: doc/BRIEF.md
# Mode Automaton Reconfiguration Controller

This block chooses which configuration a partially reconfigurable accelerator runs. Each configuration has one user event line. Those lines may be raised at any time. On every rising clock edge a normaliser turns them into exactly one event: either a named event (the index of a line) or a default event when nothing usable is present. A state graph holds one state per configuration. It consumes that single event and steps to a new state or stays where it is. The state index is the mode value, and it goes out together with a change strobe to every reconfigurable region.

Each region has a decoder. The decoder holds, for every configuration, whether the region takes part in it and which implementation it then needs. When a change of state names a configuration the region takes part in, and the needed implementation differs from the one loaded, the decoder updates its select and emits a one-cycle swap request that carries the implementation index. A region that always uses the same implementation gets no decoder. Its select is a constant and it never requests a swap. While the downstream loader reports busy, incoming events are reduced to the default event.

States: `CFG0` … `CFG(N-1)`, where state k selects configuration k. Transitions: `STEP_MOVE` goes to the state named by an enabled event. `STEP_HOLD` is the self transition taken on the default event, on an event naming the current state, or on an event whose transition is disabled.

Top module: `cfg_mode_ctrl`

## Requirements
- R1: Reset is synchronous and active high. While it is high, `cur_cfg` becomes the lowest index whose bit is set in `INIT_FLAGS` (state 1 by default). Each `region_sel` entry becomes that configuration's implementation, and `swap_req` is all zero.
- R2: Event line k is sampled at edge A. If it is the only line high, busy is low, k differs from the current state and the transition is enabled, then `cur_cfg` equals k after edge A+1.
- R3: A cycle with no event line high is a default event. The state does not change and no swap request follows.
- R4: If several event lines are high at one edge, the lowest-indexed line is the event and the others are discarded.
- R5: An event that names the current state is a self transition. So is an event whose transition bit `TRANS_EN[src*N_CFG+dst]` is 0. By default only the transition from state 2 to state 0 is disabled.
- R6: While `busy` is high at a sampling edge, any event lines are treated as the default event.
- R7: When `cur_cfg` changes after edge B, each region that takes part in the new configuration and needs a different implementation shows `swap_req` high for exactly the cycle after edge B+1. At that same edge `swap_impl` and `region_sel` take the new implementation index.
- R8: A region whose required implementation equals its loaded one gets no swap request, and its select is kept.
- R9: A region whose participation bit for the new configuration is 0 stays inactive. It raises no swap request and keeps its select. By default region 1 does not take part in configuration 2.
- R10: A region with one implementation in all its configurations (region 2 by default, implementation 0) has a constant select and never raises `swap_req`.
- R11: Each step starts from the state reached by the previous step. Events on two consecutive edges move the state twice on consecutive edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| ev_in | input | N_CFG | One event line per configuration, bit k names configuration k |
| busy | input | 1 | Reconfiguration in progress; events are suppressed |
| cur_cfg | output | SW | Current state, which is the broadcast mode value |
| region_sel | output | N_REG*IW | Active implementation index per region, region r at bits r*IW +: IW |
| swap_req | output | N_REG | One-cycle swap request per region |
| swap_impl | output | N_REG*IW | Implementation index to load, valid with swap_req |

## Verification
Single events drive the graph through every legal move. They show which regions swap, which keep an unchanged implementation and which ignore a configuration they do not take part in. Three patterns must leave the state unchanged, and each is told apart from a real step: an idle cycle, an event naming the current state, and an event on a disabled transition. An event raised while busy is also checked and must not move the state. Two lines raised together test the priority. Two events on back-to-back edges show that the second step starts from the state reached by the first, and that the resulting swap pulses land in consecutive cycles on different regions.

// File: rtl/cfg_mode_pkg.sv
package cfg_mode_pkg;

    // Normalised event class seen by the state graph
    typedef enum logic {
        EVK_DEFAULT = 1'b0,
        EVK_NAMED   = 1'b1
    } evk_e;

    // Transition kind chosen by the state graph
    typedef enum logic {
        STEP_HOLD = 1'b0,
        STEP_MOVE = 1'b1
    } step_e;

endpackage

// File: rtl/cfg_event_norm.sv
module cfg_event_norm
    import cfg_mode_pkg::*;
#(
    parameter int N_CFG = 3,
    parameter int SW    = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_CFG-1:0] ev_in,
    input  logic             busy,
    output evk_e             ev_kind,
    output logic [SW-1:0]    ev_idx
);

    logic          found;
    logic [SW-1:0] pick;

    // Priority pick: scanning downwards lets the lowest index win
    always_comb begin
        found = 1'b0;
        pick  = '0;
        for (int i = N_CFG - 1; i >= 0; i--) begin
            if (ev_in[i]) begin
                found = 1'b1;
                pick  = SW'(i);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ev_kind <= EVK_DEFAULT;
            ev_idx  <= '0;
        end else if (busy || !found) begin
            ev_kind <= EVK_DEFAULT;
            ev_idx  <= '0;
        end else begin
            ev_kind <= EVK_NAMED;
            ev_idx  <= pick;
        end
    end

    AST_BUSY_SUPPRESSES: assert property (@(posedge clk) disable iff (rst)
        busy |=> (ev_kind == EVK_DEFAULT)); // R6
    AST_IDLE_IS_DEFAULT: assert property (@(posedge clk) disable iff (rst)
        (ev_in == '0) |=> (ev_kind == EVK_DEFAULT)); // R3
    AST_EVENT_NAMED: assert property (@(posedge clk) disable iff (rst)
        (!busy && ev_in != '0) |=> (ev_kind == EVK_NAMED)); // R4

endmodule

// File: rtl/cfg_state_graph.sv
module cfg_state_graph
    import cfg_mode_pkg::*;
#(
    parameter int                     N_CFG      = 3,
    parameter int                     SW         = 2,
    parameter logic [N_CFG*N_CFG-1:0] TRANS_EN   = '1,
    parameter int                     INIT_STATE = 0
) (
    input  logic          clk,
    input  logic          rst,
    input  evk_e          ev_kind,
    input  logic [SW-1:0] ev_idx,
    output logic [SW-1:0] state_q,
    output logic          chg_q
);

    logic [N_CFG-1:0] row;
    step_e            step;
    logic [SW-1:0]    nxt;

    // Outgoing transition enables of the current state
    always_comb begin
        row = '0;
        for (int s = 0; s < N_CFG; s++) begin
            if (state_q == SW'(s)) row = TRANS_EN[s*N_CFG +: N_CFG];
        end
    end

    // Transition selection
    always_comb begin
        step = STEP_HOLD;
        unique case (ev_kind)
            EVK_DEFAULT: step = STEP_HOLD;
            EVK_NAMED: begin
                if (ev_idx != state_q && row[ev_idx]) step = STEP_MOVE;
            end
            default: step = STEP_HOLD;
        endcase
    end

    // Output (mode value) selection
    always_comb begin
        unique case (step)
            STEP_MOVE: nxt = ev_idx;
            STEP_HOLD: nxt = state_q;
            default:   nxt = state_q;
        endcase
    end

    // State register: the reached state is the source of the next step
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SW'(INIT_STATE);
            chg_q   <= 1'b0;
        end else begin
            state_q <= nxt;
            chg_q   <= (step == STEP_MOVE);
        end
    end

    AST_DEFAULT_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (ev_kind == EVK_DEFAULT) |=> (!chg_q && $stable(state_q))); // R3
    AST_MOVE_TARGET: assert property (@(posedge clk) disable iff (rst)
        chg_q |-> (state_q == $past(ev_idx))); // R2
    AST_MOVE_IS_NEW: assert property (@(posedge clk) disable iff (rst)
        chg_q |-> (state_q != $past(state_q))); // R11

endmodule

// File: rtl/cfg_region_dec.sv
module cfg_region_dec #(
    parameter int                    N_CFG      = 3,
    parameter int                    SW         = 2,
    parameter int                    IW         = 2,
    parameter logic [N_CFG*IW-1:0]   MAP        = '0,
    parameter logic [N_CFG-1:0]      MASK       = '1,
    parameter int                    INIT_STATE = 0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [SW-1:0] mode,
    input  logic          chg,
    output logic [IW-1:0] sel_q,
    output logic          swap,
    output logic [IW-1:0] swap_impl
);

    localparam logic [IW-1:0] INIT_IMPL = MAP[INIT_STATE*IW +: IW];

    logic          hit;
    logic [IW-1:0] tgt;

    // Match the broadcast mode value against this region's configurations
    always_comb begin
        hit = 1'b0;
        tgt = sel_q;
        for (int c = 0; c < N_CFG; c++) begin
            if (mode == SW'(c) && MASK[c]) begin
                hit = 1'b1;
                tgt = MAP[c*IW +: IW];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q     <= INIT_IMPL;
            swap      <= 1'b0;
            swap_impl <= INIT_IMPL;
        end else begin
            swap <= 1'b0;
            if (chg && hit && tgt != sel_q) begin
                sel_q     <= tgt;
                swap      <= 1'b1;
                swap_impl <= tgt;
            end
        end
    end

    AST_SWAP_CHANGES_SEL: assert property (@(posedge clk) disable iff (rst)
        swap |-> (sel_q != $past(sel_q))); // R7
    AST_QUIET_KEEPS_SEL: assert property (@(posedge clk) disable iff (rst)
        !swap |-> $stable(sel_q)); // R8
    AST_MISS_NO_SWAP: assert property (@(posedge clk) disable iff (rst)
        (chg && !hit) |=> !swap); // R9

endmodule

// File: rtl/cfg_mode_ctrl.sv
module cfg_mode_ctrl
    import cfg_mode_pkg::*;
#(
    parameter int                           N_CFG      = 3,
    parameter int                           N_REG      = 3,
    parameter int                           IW         = 2,
    parameter logic [N_CFG-1:0]             INIT_FLAGS = 3'b010,
    parameter logic [N_CFG*N_CFG-1:0]       TRANS_EN   = 9'b110111111,
    parameter logic [N_REG*N_CFG*IW-1:0]    IMPL_MAP   = 18'b00_00_00_00_01_00_01_01_00,
    parameter logic [N_REG*N_CFG-1:0]       REG_MASK   = 9'b111011111,
    localparam int                          SW         = (N_CFG > 1) ? $clog2(N_CFG) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N_CFG-1:0]  ev_in,
    input  logic              busy,
    output logic [SW-1:0]     cur_cfg,
    output logic [N_REG*IW-1:0] region_sel,
    output logic [N_REG-1:0]  swap_req,
    output logic [N_REG*IW-1:0] swap_impl
);

    // Lowest state whose initial flag is set
    function automatic int init_state();
        int res = 0;
        for (int i = N_CFG - 1; i >= 0; i--) begin
            if (INIT_FLAGS[i]) res = i;
        end
        return res;
    endfunction

    // A region is fixed when every configuration it joins uses one implementation
    function automatic bit is_fixed(int r);
        bit            seen = 0;
        bit            same = 1;
        logic [IW-1:0] first = '0;
        for (int c = 0; c < N_CFG; c++) begin
            if (REG_MASK[r*N_CFG + c]) begin
                if (!seen) begin
                    seen  = 1;
                    first = IMPL_MAP[(r*N_CFG + c)*IW +: IW];
                end else if (IMPL_MAP[(r*N_CFG + c)*IW +: IW] != first) begin
                    same = 0;
                end
            end
        end
        return same;
    endfunction

    function automatic logic [IW-1:0] fixed_impl(int r);
        logic [IW-1:0] v = '0;
        for (int c = N_CFG - 1; c >= 0; c--) begin
            if (REG_MASK[r*N_CFG + c]) v = IMPL_MAP[(r*N_CFG + c)*IW +: IW];
        end
        return v;
    endfunction

    localparam int INIT_ST = init_state();

    evk_e          ev_kind;
    logic [SW-1:0] ev_idx;
    logic [SW-1:0] state_q;
    logic          chg_q;

    cfg_event_norm #(.N_CFG(N_CFG), .SW(SW)) u_norm (
        .clk    (clk),
        .rst    (rst),
        .ev_in  (ev_in),
        .busy   (busy),
        .ev_kind(ev_kind),
        .ev_idx (ev_idx)
    );

    cfg_state_graph #(
        .N_CFG     (N_CFG),
        .SW        (SW),
        .TRANS_EN  (TRANS_EN),
        .INIT_STATE(INIT_ST)
    ) u_graph (
        .clk    (clk),
        .rst    (rst),
        .ev_kind(ev_kind),
        .ev_idx (ev_idx),
        .state_q(state_q),
        .chg_q  (chg_q)
    );

    assign cur_cfg = state_q;

    for (genvar r = 0; r < N_REG; r++) begin : g_region
        if (is_fixed(r)) begin : g_fixed
            assign region_sel[r*IW +: IW] = fixed_impl(r);
            assign swap_req[r]            = 1'b0;
            assign swap_impl[r*IW +: IW]  = fixed_impl(r);
        end else begin : g_dec
            cfg_region_dec #(
                .N_CFG     (N_CFG),
                .SW        (SW),
                .IW        (IW),
                .MAP       (IMPL_MAP[r*N_CFG*IW +: N_CFG*IW]),
                .MASK      (REG_MASK[r*N_CFG +: N_CFG]),
                .INIT_STATE(INIT_ST)
            ) u_dec (
                .clk      (clk),
                .rst      (rst),
                .mode     (state_q),
                .chg      (chg_q),
                .sel_q    (region_sel[r*IW +: IW]),
                .swap     (swap_req[r]),
                .swap_impl(swap_impl[r*IW +: IW])
            );
        end
    end

    AST_CFG_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        (int'(cur_cfg) < N_CFG)); // R2
    AST_RESET_NO_SWAP: assert property (@(posedge clk)
        rst |=> (swap_req == '0)); // R1

endmodule

// File: tb/cfg_mode_ctrl_bench.sv
module cfg_mode_ctrl_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] ev_in = '0;
    logic       busy = 1'b0;
    logic [1:0] cur_cfg;
    logic [5:0] region_sel;
    logic [2:0] swap_req;
    logic [5:0] swap_impl;

    int n_checks = 0;
    int n_fail   = 0;

    always #2.5 clk = ~clk;

    cfg_mode_ctrl u_cfg_mode_ctrl (
        .clk       (clk),
        .rst       (rst),
        .ev_in     (ev_in),
        .busy      (busy),
        .cur_cfg   (cur_cfg),
        .region_sel(region_sel),
        .swap_req  (swap_req),
        .swap_impl (swap_impl)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic chk_sel(input int s0, input int s1, input string tag);
        chk(region_sel[1:0] == 2'(s0), {tag, " sel r0"}, region_sel[1:0], s0);
        chk(region_sel[3:2] == 2'(s1), {tag, " sel r1"}, region_sel[3:2], s1);
        chk(region_sel[5:4] == 2'd0, "R10 sel r2 fixed", region_sel[5:4], 0);
    endtask

    // One event presented for one edge, then the resulting state and swaps
    task automatic step(input logic [2:0] ev, input logic bz, input int ecfg,
                        input logic [2:0] eswap, input int s0, input int s1,
                        input string tag);
        @(negedge clk); ev_in = ev; busy = bz;
        @(posedge clk);
        @(negedge clk); ev_in = '0; busy = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk(cur_cfg == 2'(ecfg), {tag, " state"}, cur_cfg, ecfg);
        @(posedge clk);
        @(negedge clk);
        chk(swap_req == eswap, {tag, " swap pulse"}, swap_req, eswap);
        chk_sel(s0, s1, tag);
        if (eswap[0]) chk(swap_impl[1:0] == 2'(s0), {tag, " impl r0"}, swap_impl[1:0], s0);
        if (eswap[1]) chk(swap_impl[3:2] == 2'(s1), {tag, " impl r1"}, swap_impl[3:2], s1);
        @(posedge clk);
        @(negedge clk);
        chk(swap_req == 3'b000, "R7 pulse one cycle", swap_req, 0);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(cur_cfg == 2'd1, "R1 initial state", cur_cfg, 1);
        chk(swap_req == 3'b000, "R1 no swap", swap_req, 0);
        chk_sel(1, 1, "R1");
    endtask

    task automatic t_idle();
        repeat (4) @(negedge clk);
        chk(cur_cfg == 2'd1, "R3 idle holds", cur_cfg, 1);
        chk(swap_req == 3'b000, "R3 idle no swap", swap_req, 0);
    endtask

    task automatic t_chain();
        @(negedge clk); ev_in = 3'b100;
        @(posedge clk);
        @(negedge clk); ev_in = 3'b010;
        @(posedge clk);
        @(negedge clk); ev_in = 3'b000;
        chk(cur_cfg == 2'd2, "R11 first step", cur_cfg, 2);
        @(posedge clk);
        @(negedge clk);
        chk(cur_cfg == 2'd1, "R11 second step", cur_cfg, 1);
        chk(swap_req == 3'b001, "R11 r0 swap after first", swap_req, 1);
        chk(swap_impl[1:0] == 2'd1, "R11 r0 impl", swap_impl[1:0], 1);
        @(posedge clk);
        @(negedge clk);
        chk(swap_req == 3'b010, "R11 r1 swap after second", swap_req, 2);
        chk_sel(1, 1, "R11");
    endtask

    initial begin
        #(5.0 * 20000);
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", n_checks, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        t_reset();
        t_idle();
        step(3'b001, 1'b0, 0, 3'b011, 0, 0, "R2 R7 event e0");
        step(3'b001, 1'b0, 0, 3'b000, 0, 0, "R5 self event");
        step(3'b100, 1'b0, 2, 3'b001, 1, 0, "R9 event e2 r1 inactive");
        step(3'b001, 1'b0, 2, 3'b000, 1, 0, "R5 disabled transition");
        step(3'b010, 1'b0, 1, 3'b010, 1, 1, "R8 event e1 r0 unchanged");
        step(3'b001, 1'b1, 1, 3'b000, 1, 1, "R6 busy suppresses");
        step(3'b101, 1'b0, 0, 3'b011, 0, 0, "R4 lowest wins");
        t_chain();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule